// File: doc/BRIEF.md
# Inertial Sample Byte Streamer

This block turns seven-word inertial samples (three acceleration axes, temperature, three rotation axes) into a byte stream for a host that pulls an arbitrary number of bytes per read. It holds one 14-byte snapshot and a byte cursor into it. A fresh sample is requested from the capture side only when a read begins with the cursor at zero. A host that reads the snapshot in several short pieces therefore never receives a mix of old and new values.

A read starts with a one-cycle strobe carrying the requested byte count. The block sends bytes over a valid/ready interface, then pulses a completion flag together with the number of bytes actually sent. Each word can optionally be re-coded from two's complement to offset binary as it is captured. A separate clear input returns the cursor to zero when a host session opens or closes.

Top module: `imu_byte_streamer`

## Requirements
- R1: After reset `out_valid`, `smp_req` and `rd_done` are low and the cursor is at zero, so the first non-empty read fetches a sample.
- R2: `smp_data` carries the words in bits [111:96] accel X, [95:80] accel Y, [79:64] accel Z, [63:48] temperature, [47:32] gyro X, [31:16] gyro Y, [15:0] gyro Z. Bytes leave in that word order, high byte of each word first.
- R3: A sample is requested only when a non-empty read starts with the cursor at zero. A read that starts elsewhere continues from the held snapshot without raising `smp_req`.
- R4: A read sends min(14 - cursor, requested) bytes. `rd_done` pulses for one cycle after the last handshake, with `rd_count` equal to the bytes sent.
- R5: The cursor returns to zero after byte 13 is sent, so the next read fetches a fresh sample.
- R6: With `offset_mode` high at capture, 0x8000 is added modulo 2^16 to each word: 0x8000 is sent as 0x00,0x00 and 0x7FFF as 0xFF,0xFF. With it low, words pass unchanged.
- R7: A one-cycle `cursor_clear` while idle sets the cursor to zero, so the next read fetches a new sample.
- R8: While `out_valid` is high and `out_ready` low, `out_byte` holds and the cursor stalls. No byte is lost or repeated.
- R9: `smp_req` stays high until `smp_ack`, and `out_valid` is low throughout the fetch.
- R10: A read of zero bytes pulses `rd_done` with `rd_count` 0 on the next cycle, without a fetch and without sending a byte.
- R11: A `rd_start` strobe during a read in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cursor_clear | input | 1 | Forces the byte cursor to zero |
| offset_mode | input | 1 | Offset-binary conversion at capture |
| rd_start | input | 1 | Read start strobe |
| rd_len | input | 8 | Requested byte count, sampled with `rd_start` |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_count | output | 8 | Bytes sent by the completed read |
| smp_req | output | 1 | Sample fetch request |
| smp_ack | input | 1 | Sample fetch acknowledge; data captured this cycle |
| smp_data | input | 112 | Sample words, accel X in the top bits |
| out_byte | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |

## Verification
The assertions assume that `cursor_clear` is used only between reads, and that `smp_ack` arrives only while `smp_req` is high. The byte-hold property also assumes that no clear is pending, because a clear moves the cursor. The stimulus pulses the clear only while no read is in progress. It raises the acknowledge only after it has seen a request, after a random delay, and drops it once the request falls. Random lengths from 0 to 20, random back-pressure and both coding modes are mixed with directed reads: a wrap, a zero-length read, an injected mid-read strobe and known extreme words.

// File: rtl/imu_byte_streamer.sv
module imu_byte_streamer #(
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 7,
  parameter int LEN_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cursor_clear,
  input  logic                      offset_mode,
  input  logic                      rd_start,
  input  logic [LEN_W-1:0]          rd_len,
  output logic                      rd_done,
  output logic [LEN_W-1:0]          rd_count,
  output logic                      smp_req,
  input  logic                      smp_ack,
  input  logic [N_WORDS*WORD_W-1:0] smp_data,
  output logic [7:0]                out_byte,
  output logic                      out_valid,
  input  logic                      out_ready
);
  localparam int SNAP_W = N_WORDS * WORD_W;
  localparam int NB     = SNAP_W / 8;
  localparam int CUR_W  = $clog2(NB);
  localparam logic [CUR_W-1:0] LAST_IDX = CUR_W'(NB - 1);
  localparam logic [WORD_W-1:0] BIAS = {1'b1, {(WORD_W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND} state_t;

  state_t             state;
  logic [SNAP_W-1:0]  snap, conv;
  logic [CUR_W-1:0]   cursor;
  logic [LEN_W-1:0]   remain, sent;
  logic               fire, last;

  always_comb begin
    for (int w = 0; w < N_WORDS; w++)
      conv[w*WORD_W +: WORD_W] = smp_data[w*WORD_W +: WORD_W] + (offset_mode ? BIAS : '0);
  end

  assign smp_req   = (state == S_FETCH);
  assign out_valid = (state == S_SEND);
  assign out_byte  = snap[SNAP_W-1-8*int'(cursor) -: 8];
  assign fire      = out_valid && out_ready;
  assign last      = (remain == LEN_W'(1)) || (cursor == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      snap     <= '0;
      remain   <= '0;
      sent     <= '0;
      rd_done  <= 1'b0;
      rd_count <= '0;
    end else begin
      rd_done <= 1'b0;
      case (state)
        S_IDLE:
          if (rd_start) begin
            if (rd_len == '0) begin
              rd_done  <= 1'b1;
              rd_count <= '0;
            end else begin
              remain <= rd_len;
              sent   <= '0;
              state  <= (cursor == '0) ? S_FETCH : S_SEND;
            end
          end
        S_FETCH:
          if (smp_ack) begin
            snap  <= conv;
            state <= S_SEND;
          end
        S_SEND:
          if (out_ready) begin
            sent   <= sent + 1'b1;
            remain <= remain - 1'b1;
            if (last) begin
              state    <= S_IDLE;
              rd_done  <= 1'b1;
              rd_count <= sent + 1'b1;
            end
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            cursor <= '0;
    else if (cursor_clear) cursor <= '0;
    else if (fire)         cursor <= (cursor == LAST_IDX) ? '0 : cursor + 1'b1;
  end

  AST_NO_VALID_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> !out_valid); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req && !smp_ack |=> smp_req); // R9
  AST_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> cursor == '0); // R3
  AST_CURSOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cursor <= LAST_IDX); // R5
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !cursor_clear |=> out_valid && $stable(out_byte)); // R8
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_count <= LEN_W'(NB)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done); // R4
endmodule

// File: tb/imu_byte_streamer_tb.sv
module imu_byte_streamer_tb_top;
  logic clk = 0, rst_n = 0;
  logic cursor_clear = 0, offset_mode = 0, rd_start = 0, smp_ack = 0, out_ready = 0;
  logic [7:0] rd_len = 0, rd_count, out_byte;
  logic rd_done, smp_req, out_valid;
  logic [111:0] smp_data = '0;

  imu_byte_streamer dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int cur_m = 0;
  logic [111:0] snap_m = '0;
  logic mode_m = 0;
  bit use_fixed = 0;
  logic [111:0] fixed_smp = '0;
  logic [7:0] got [0:31];

  function automatic logic [7:0] exp_byte(logic [111:0] s, int idx, logic m);
    logic [15:0] w;
    w = s[111-16*(idx/2) -: 16];
    if (m) w = w + 16'h8000;
    return (idx % 2) ? w[7:0] : w[15:8];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(int len, bit inject);
    int exp_n, sent = 0, fetches = 0, delay, cyc = 0;
    bit injected = 0, exp_fetch;
    exp_n = (len < 14 - cur_m) ? len : 14 - cur_m;
    exp_fetch = (len > 0) && (cur_m == 0);
    delay = $urandom_range(0, 3);
    @(negedge clk);
    rd_len = 8'(len); rd_start = 1;
    @(negedge clk);
    rd_start = 0;
    forever begin
      if (rd_start) rd_start = 0;
      if (rd_done) break;
      if (++cyc > 1000) begin chk(0, "R4 timeout", cyc, 0); break; end
      if (smp_req) begin
        chk(!out_valid, "R9 valid during fetch", out_valid, 0);
        if (!smp_ack) begin
          chk(cur_m == 0, "R3 fetch off zero", cur_m, 0);
          if (delay == 0) begin
            smp_ack = 1;
            smp_data = use_fixed ? fixed_smp : {$urandom(), $urandom(), $urandom(), 16'($urandom())};
            snap_m = smp_data; mode_m = offset_mode; fetches++;
          end else delay--;
        end
      end else smp_ack = 0;
      if (out_valid) begin
        chk(out_byte == exp_byte(snap_m, cur_m, mode_m), "R2/R8 byte", out_byte, exp_byte(snap_m, cur_m, mode_m));
        if (inject && !injected) begin rd_start = 1; rd_len = 8'd1; injected = 1; end
        out_ready = ($urandom_range(0, 9) < 7);
        if (out_ready) begin
          if (sent < 32) got[sent] = out_byte;
          sent++; cur_m = (cur_m == 13) ? 0 : cur_m + 1;
        end
      end else out_ready = 0;
      @(negedge clk);
    end
    smp_ack = 0; out_ready = 0;
    chk(int'(rd_count) == exp_n, inject ? "R11 count" : "R4 count", rd_count, exp_n);
    chk(sent == exp_n, len == 0 ? "R10 bytes" : "R4 bytes", sent, exp_n);
    chk(fetches == int'(exp_fetch), "R3 fetch", fetches, exp_fetch);
  endtask

  initial begin
    #200000;
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    chk(!out_valid && !smp_req && !rd_done, "R1 reset outputs", {out_valid, smp_req, rd_done}, 0);
    rst_n = 1;
    do_read(0, 0);                       // R10
    do_read(5, 0);                       // R1 fetch at zero, R4
    do_read(4, 0);                       // R3 continue
    do_read(20, 0);                      // R4 clip, R5 wrap
    chk(cur_m == 0, "R5 wrap", cur_m, 0);
    do_read(3, 0);                       // R5 new fetch
    @(negedge clk) cursor_clear = 1;     // R7
    @(negedge clk) cursor_clear = 0;
    cur_m = 0;
    do_read(2, 0);                       // R7 fetch after clear
    do_read(6, 1);                       // R11 injected strobe
    @(negedge clk) cursor_clear = 1;
    @(negedge clk) cursor_clear = 0;
    cur_m = 0;
    use_fixed = 1; offset_mode = 1;
    fixed_smp = {16'h8000, 16'h7FFF, 16'h0000, 16'h1234, 48'h0};
    do_read(6, 0);                       // R6
    chk({got[0], got[1], got[2], got[3]} == 32'h0000FFFF, "R6 extremes", {got[0], got[1], got[2], got[3]}, 32'h0000FFFF);
    chk({got[4], got[5]} == 16'h8000, "R6 zero", {got[4], got[5]}, 16'h8000);
    offset_mode = 0;
    do_read(20, 0);
    @(negedge clk) cursor_clear = 1;
    @(negedge clk) cursor_clear = 0;
    cur_m = 0;
    do_read(4, 0);                       // R2 plain order
    chk({got[0], got[1], got[2], got[3]} == 32'h80007FFF, "R2 order", {got[0], got[1], got[2], got[3]}, 32'h80007FFF);
    use_fixed = 0;
    for (int i = 0; i < 60; i++) begin
      offset_mode = $urandom_range(0, 1);
      do_read($urandom_range(0, 20), 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule